// File: doc/BRIEF.md
# Banked Byte Flash Access Port

This block lets a requester reach single bytes of a parallel flash through a controller that only offers a 16-bit flash address register, a data register, a control word and a half-select register. A 20-bit byte address is split. The low 16 bits go into the flash address register. The upper bits go into bank bits of the control word. The block then moves one byte through the data register. Commands come in on a request/acknowledge port: open a session, close it, read one byte, or write one byte. Each command goes out as a series of single register transfers on a downstream register bus.

The parameter `LARGE_PART` picks one of two addressing modes. In the 128 KiB mode, one bank bit follows address bit 16. The control word is rewritten only when that bit must change. A read samples the data register until two consecutive samples agree. A half-select register bit is kept in step with the upper half of the part. In the 1 MiB mode, every access rewrites the control word with a four-bit upper-address field and the bank bit set. A read then takes a single sample. In both modes, every write to the control word or to the select register is followed at once by a read of the same register, so the update is known to have landed before the next access.

Top module: `flash_bank_port`

## Requirements
- R1: After reset the port raises no acknowledge and makes no downstream request until a command arrives.
- R2: An open command writes the control word with the enable bit (bit 1) set and all other bits kept. In the 128 KiB mode it then writes 0 to the select register (register code 3, bit 0). In the 1 MiB mode the select register is never written.
- R3: A close command writes the control word with the enable bit (bit 1) cleared and all other bits kept.
- R4: In the 128 KiB mode the bank bit (control bit 3) equals address bit 16 at every data access. The control word is written only when that bit has to change.
- R5: In the 1 MiB mode every read or write first writes the control word. That write clears bits 7:3, places address bits 19:16 in bits 7:4, sets bit 3, and keeps the other bits.
- R6: Every write to the control word (register code 0) or to the select register (register code 3) is immediately followed by a read of that same register. No other transfer comes in between.
- R7: The flash address register (code 1) receives address bits 15:0 before the data access. A byte write puts the byte in bits 7:0 of the data register (code 2), with bits 15:8 zero.
- R8: In the 128 KiB mode a read samples the data register until two consecutive 16-bit samples are equal. It then returns bits 7:0 of that sample with the error flag clear.
- R9: In the 128 KiB mode a read takes at most `MAX_TRIES` (16) samples. If no two consecutive samples agree by then, it returns bits 7:0 of the last sample with the error flag set.
- R10: In the 1 MiB mode a read takes exactly one data sample and returns its bits 7:0 with the error flag clear.
- R11: In the 128 KiB mode, at every data access the select register bit 0 equals 1 when the address is at or above half the part size and 0 otherwise. It is written only when its value must change.
- R12: Each command gets exactly one acknowledge pulse of one cycle. A downstream request stays asserted, with its fields stable, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, held until acknowledged |
| cmd_op | input | 2 | 0 open, 1 close, 2 read byte, 3 write byte |
| cmd_addr | input | 20 | Byte address |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ack | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | 8 | Byte read, valid from the acknowledge on |
| cmd_err | output | 1 | Read gave up without two agreeing samples |
| bus_req | output | 1 | Downstream transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_reg | output | 2 | 0 control, 1 flash address, 2 data, 3 select |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Transfer done |
| bus_rdata | input | 16 | Read data, valid with bus_ack |

## Verification
The hardest cases to reach are reads whose data register stays unsettled for exactly the bound, one sample short of it, and beyond it. Only there do the agree-on-the-last-try and give-up paths separate. The bench's register model can be armed before each command with a count of deliberately changing samples to return before the true byte. It is armed with 14, 15 and 20, which cover a match on the sixteenth sample, a give-up whose last sample is the true byte, and a give-up on a noise word. The lazy bank and select updates are reached by address orders that cross bit 16 in both directions and then stay on one side.

// File: rtl/flash_bank_pkg.sv
package flash_bank_pkg;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_FADDR = 2'd1;
  localparam logic [1:0] REG_FDATA = 2'd2;
  localparam logic [1:0] REG_SEL = 2'd3;

  localparam int CTL_EN_BIT = 1;
  localparam int CTL_BANK_BIT = 3;
  localparam logic [15:0] CTL_WIDE_CLEAR = 16'h00F8;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_CLOSE = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  // 1 MiB mode: clear bank field, insert upper address nibble, set bank bit
  function automatic logic [15:0] wide_bank_word(input logic [15:0] cur,
                                                 input logic [3:0] upper);
    logic [15:0] w;
    w = cur & ~CTL_WIDE_CLEAR;
    w[7:4] = upper;
    w[CTL_BANK_BIT] = 1'b1;
    return w;
  endfunction

  // 128 KiB mode: bank bit follows address bit 16
  function automatic logic [15:0] narrow_bank_word(input logic [15:0] cur,
                                                   input logic b16);
    logic [15:0] w;
    w = cur;
    w[CTL_BANK_BIT] = b16;
    return w;
  endfunction

endpackage

// File: rtl/fbp_bank_calc.sv
module fbp_bank_calc
  import flash_bank_pkg::*;
#(
  parameter bit LARGE_PART = 1'b0,
  parameter int ADDR_W = 20,
  parameter int ROM_BYTES = 1 << 17
) (
  input  logic [15:0]       shadow,
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       bank_word,
  output logic              bank_chg,
  output logic              sel_hi
);
  localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(ROM_BYTES / 2);

  generate
    if (LARGE_PART) begin : g_wide
      assign bank_word = wide_bank_word(shadow, addr[ADDR_W-1:16]);
      assign bank_chg = 1'b1;
      assign sel_hi = 1'b0;
    end else begin : g_narrow
      assign bank_word = narrow_bank_word(shadow, addr[16]);
      assign bank_chg = shadow[CTL_BANK_BIT] != addr[16];
      assign sel_hi = addr >= HALF_A;
    end
  endgenerate

endmodule

// File: rtl/fbp_sample_filter.sv
module fbp_sample_filter #(
  parameter bit FILTER = 1'b1,
  parameter int MAX_TRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        smp_v,
  input  logic [15:0] smp,
  output logic        done,
  output logic        bad,
  output logic [15:0] value
);
  localparam int TW = $clog2(MAX_TRIES + 1);

  assign value = smp;

  generate
    if (FILTER) begin : g_filter
      logic [TW-1:0] cnt;
      logic [15:0] prev;
      logic agree, last_try;

      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          cnt <= '0;
          prev <= '0;
        end else if (smp_v) begin
          prev <= smp;
          cnt <= cnt + 1'b1;
        end
      end

      assign agree = (cnt != '0) && (smp == prev);
      assign last_try = cnt == TW'(MAX_TRIES - 1);
      assign done = smp_v && (agree || last_try);
      assign bad = smp_v && last_try && !agree;

      assert_tries_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TW'(MAX_TRIES));
      assert_no_early_quit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_v && !last_try && (cnt == '0)) |-> !done);
    end else begin : g_single
      assign done = smp_v;
      assign bad = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/fbp_sequencer.sv
module fbp_sequencer
  import flash_bank_pkg::*;
#(
  parameter bit LARGE_PART = 1'b0,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              cmd_ack,
  output logic [7:0]        cmd_rdata,
  output logic              cmd_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [1:0]        bus_reg,
  output logic [15:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [15:0]       bus_rdata,
  output logic [15:0]       shadow,
  output logic [ADDR_W-1:0] addr_q,
  input  logic [15:0]       bank_word,
  input  logic              bank_chg,
  input  logic              sel_hi,
  output logic              flt_clear,
  output logic              smp_v,
  output logic [15:0]       smp,
  input  logic              flt_done,
  input  logic              flt_bad,
  input  logic [15:0]       flt_value
);
  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_CW, S_CR, S_SW, S_SR, S_AW, S_DW, S_DR, S_DONE
  } st_e;

  st_e st;
  op_e op_q;
  logic [7:0] wd_q;
  logic [15:0] cw_q;
  logic sel_q, sv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= OP_OPEN;
      addr_q <= '0;
      wd_q <= '0;
      cw_q <= '0;
      shadow <= '0;
      sel_q <= 1'b0;
      sv_q <= 1'b0;
      cmd_rdata <= '0;
      cmd_err <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          op_q <= op_e'(cmd_op);
          addr_q <= cmd_addr;
          wd_q <= cmd_wdata;
          cmd_err <= 1'b0;
          unique case (op_e'(cmd_op))
            OP_OPEN: begin
              cw_q <= shadow | (16'd1 << CTL_EN_BIT);
              st <= S_CW;
            end
            OP_CLOSE: begin
              cw_q <= shadow & ~(16'd1 << CTL_EN_BIT);
              st <= S_CW;
            end
            default: st <= S_PLAN;
          endcase
        end
        S_PLAN: begin
          if (!LARGE_PART && (sel_hi != sel_q)) begin
            sv_q <= sel_hi;
            st <= S_SW;
          end else if (bank_chg) begin
            cw_q <= bank_word;
            st <= S_CW;
          end else begin
            st <= S_AW;
          end
        end
        S_CW: if (bus_ack) begin
          shadow <= cw_q;
          st <= S_CR;
        end
        S_CR: if (bus_ack) begin
          if (op_q == OP_OPEN && !LARGE_PART) begin
            sv_q <= 1'b0;
            st <= S_SW;
          end else if (op_q == OP_OPEN || op_q == OP_CLOSE) begin
            st <= S_DONE;
          end else begin
            st <= S_AW;
          end
        end
        S_SW: if (bus_ack) begin
          sel_q <= sv_q;
          st <= S_SR;
        end
        S_SR: if (bus_ack) st <= (op_q == OP_OPEN) ? S_DONE : S_PLAN;
        S_AW: if (bus_ack) st <= (op_q == OP_WRITE) ? S_DW : S_DR;
        S_DW: if (bus_ack) st <= S_DONE;
        S_DR: if (bus_ack && flt_done) begin
          cmd_rdata <= flt_value[7:0];
          cmd_err <= flt_bad;
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req = 1'b1;
    bus_we = 1'b0;
    bus_reg = REG_CTRL;
    bus_wdata = '0;
    unique case (st)
      S_CW: begin bus_we = 1'b1; bus_wdata = cw_q; end
      S_CR: ;
      S_SW: begin bus_we = 1'b1; bus_reg = REG_SEL; bus_wdata = {15'd0, sv_q}; end
      S_SR: bus_reg = REG_SEL;
      S_AW: begin bus_we = 1'b1; bus_reg = REG_FADDR; bus_wdata = addr_q[15:0]; end
      S_DW: begin bus_we = 1'b1; bus_reg = REG_FDATA; bus_wdata = {8'd0, wd_q}; end
      S_DR: bus_reg = REG_FDATA;
      default: bus_req = 1'b0;
    endcase
  end

  assign cmd_ack = st == S_DONE;
  assign flt_clear = st == S_AW;
  assign smp_v = (st == S_DR) && bus_ack;
  assign smp = bus_rdata;

  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cmd_ack);
  assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_reg) && $stable(bus_we)
                               && $stable(bus_wdata)));
  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we && (bus_reg == REG_CTRL || bus_reg == REG_SEL))
      |=> (bus_req && !bus_we && bus_reg == $past(bus_reg)));

  generate
    if (LARGE_PART) begin : g_chk_wide
      assert_bank_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_reg == REG_FDATA) |->
          (shadow[7:4] == addr_q[ADDR_W-1:16] && shadow[CTL_BANK_BIT]));
      assert_no_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_reg != REG_SEL);
    end else begin : g_chk_narrow
      assert_bank_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_reg == REG_FDATA) |-> shadow[CTL_BANK_BIT] == addr_q[16]);
      assert_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_reg == REG_FDATA) |-> sel_q == sel_hi);
    end
  endgenerate

endmodule

// File: rtl/flash_bank_port.sv
module flash_bank_port
  import flash_bank_pkg::*;
#(
  parameter bit LARGE_PART = 1'b0,
  parameter int ADDR_W = 20,
  parameter int MAX_TRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              cmd_ack,
  output logic [7:0]        cmd_rdata,
  output logic              cmd_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [1:0]        bus_reg,
  output logic [15:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [15:0]       bus_rdata
);
  localparam int ROM_BYTES = LARGE_PART ? (1 << ADDR_W) : (1 << 17);

  logic [15:0] shadow, bank_word, smp, flt_value;
  logic [ADDR_W-1:0] addr_q;
  logic bank_chg, sel_hi, flt_clear, smp_v, flt_done, flt_bad;

  fbp_bank_calc #(
    .LARGE_PART(LARGE_PART), .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)
  ) u_calc (
    .shadow(shadow), .addr(addr_q), .bank_word(bank_word),
    .bank_chg(bank_chg), .sel_hi(sel_hi)
  );

  fbp_sample_filter #(
    .FILTER(!LARGE_PART), .MAX_TRIES(MAX_TRIES)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .clear(flt_clear), .smp_v(smp_v), .smp(smp),
    .done(flt_done), .bad(flt_bad), .value(flt_value)
  );

  fbp_sequencer #(
    .LARGE_PART(LARGE_PART), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata),
    .cmd_err(cmd_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .shadow(shadow), .addr_q(addr_q), .bank_word(bank_word),
    .bank_chg(bank_chg), .sel_hi(sel_hi),
    .flt_clear(flt_clear), .smp_v(smp_v), .smp(smp),
    .flt_done(flt_done), .flt_bad(flt_bad), .flt_value(flt_value)
  );

endmodule

// File: tb/flash_bank_port_bench.sv
module flash_bus_model #(parameter bit BIG = 1'b0) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [1:0]  bus_reg,
  input  logic [15:0] bus_wdata,
  output logic        bus_ack,
  output logic [15:0] bus_rdata,
  input  logic        arm,
  input  logic [7:0]  arm_n
);
  logic [15:0] ctrl, faddr, sel, lastw;
  int cw_cnt, sw_cnt, drd_cnt, viol, noise_left, gidx;
  logic pend;
  logic [1:0] pend_reg;
  logic [19:0] eff;

  assign eff = BIG ? {ctrl[7:4], faddr} : {3'd0, ctrl[3], faddr};

  function automatic logic [15:0] fval(input logic [19:0] e);
    return {4'h0, e[19:16], e[7:0] ^ e[15:8]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_rdata <= '0;
      ctrl <= '0; faddr <= '0; sel <= '0; lastw <= '0;
      cw_cnt <= 0; sw_cnt <= 0; drd_cnt <= 0; viol <= 0;
      noise_left <= 0; gidx <= 0; pend <= 1'b0; pend_reg <= '0;
    end else begin
      if (arm) begin noise_left <= int'(arm_n); gidx <= 0; end
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && !bus_ack) begin
        if (pend && (bus_we || bus_reg != pend_reg)) viol <= viol + 1;
        pend <= bus_we && (bus_reg == 2'd0 || bus_reg == 2'd3);
        pend_reg <= bus_reg;
        if (bus_we) begin
          case (bus_reg)
            2'd0: begin ctrl <= bus_wdata; cw_cnt <= cw_cnt + 1; end
            2'd1: faddr <= bus_wdata;
            2'd2: lastw <= bus_wdata;
            default: begin sel <= bus_wdata; sw_cnt <= sw_cnt + 1; end
          endcase
        end else begin
          case (bus_reg)
            2'd0: bus_rdata <= ctrl;
            2'd1: bus_rdata <= faddr;
            2'd2: begin
              drd_cnt <= drd_cnt + 1;
              if (noise_left > 0) begin
                bus_rdata <= 16'hE000 | 16'(gidx);
                gidx <= gidx + 1;
                noise_left <= noise_left - 1;
              end else begin
                bus_rdata <= fval(eff);
              end
            end
            default: bus_rdata <= sel;
          endcase
        end
      end
    end
  end
endmodule

module flash_bank_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  logic s_valid = 0, l_valid = 0;
  logic [1:0] s_op = 0, l_op = 0;
  logic [19:0] s_addr = 0, l_addr = 0;
  logic [7:0] s_wd = 0, l_wd = 0;
  logic s_ack, l_ack, s_err, l_err;
  logic [7:0] s_rd, l_rd;
  logic s_req, l_req, s_we, l_we, s_back, l_back;
  logic [1:0] s_reg, l_reg;
  logic [15:0] s_wdat, l_wdat, s_rdat, l_rdat;
  logic s_arm = 0, l_arm = 0;
  logic [7:0] s_an = 0, l_an = 0;

  flash_bank_port #(.LARGE_PART(1'b0)) u_flash_bank_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(s_valid), .cmd_op(s_op),
    .cmd_addr(s_addr), .cmd_wdata(s_wd), .cmd_ack(s_ack), .cmd_rdata(s_rd),
    .cmd_err(s_err), .bus_req(s_req), .bus_we(s_we), .bus_reg(s_reg),
    .bus_wdata(s_wdat), .bus_ack(s_back), .bus_rdata(s_rdat));
  flash_bus_model #(.BIG(1'b0)) u_ms (
    .clk(clk), .rst_n(rst_n), .bus_req(s_req), .bus_we(s_we), .bus_reg(s_reg),
    .bus_wdata(s_wdat), .bus_ack(s_back), .bus_rdata(s_rdat),
    .arm(s_arm), .arm_n(s_an));

  flash_bank_port #(.LARGE_PART(1'b1)) u_flash_bank_port_big (
    .clk(clk), .rst_n(rst_n), .cmd_valid(l_valid), .cmd_op(l_op),
    .cmd_addr(l_addr), .cmd_wdata(l_wd), .cmd_ack(l_ack), .cmd_rdata(l_rd),
    .cmd_err(l_err), .bus_req(l_req), .bus_we(l_we), .bus_reg(l_reg),
    .bus_wdata(l_wdat), .bus_ack(l_back), .bus_rdata(l_rdat));
  flash_bus_model #(.BIG(1'b1)) u_ml (
    .clk(clk), .rst_n(rst_n), .bus_req(l_req), .bus_we(l_we), .bus_reg(l_reg),
    .bus_wdata(l_wdat), .bus_ack(l_back), .bus_rdata(l_rdat),
    .arm(l_arm), .arm_n(l_an));

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] addr;
    logic [7:0]  wd;
    logic [7:0]  noise;
    logic [15:0] e_ctrl;
    logic        e_sel;
    logic [3:0]  e_cw;
    logic [3:0]  e_sw;
    logic [7:0]  e_ns;
    logic [7:0]  e_rd;
    logic        e_err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 20'h00000, 8'h00, 8'd0,  16'h0002, 1'b0, 4'd1, 4'd1, 8'd0,  8'h00, 1'b0},
    '{2'd2, 20'h01234, 8'h00, 8'd0,  16'h0002, 1'b0, 4'd0, 4'd0, 8'd2,  8'h26, 1'b0},
    '{2'd3, 20'h10055, 8'hA7, 8'd0,  16'h000A, 1'b1, 4'd1, 4'd1, 8'd0,  8'h00, 1'b0},
    '{2'd2, 20'h1FF00, 8'h00, 8'd3,  16'h000A, 1'b1, 4'd0, 4'd0, 8'd5,  8'hFF, 1'b0},
    '{2'd2, 20'h0ABCD, 8'h00, 8'd14, 16'h0002, 1'b0, 4'd1, 4'd1, 8'd16, 8'h66, 1'b0},
    '{2'd2, 20'h00010, 8'h00, 8'd15, 16'h0002, 1'b0, 4'd0, 4'd0, 8'd16, 8'h10, 1'b1},
    '{2'd2, 20'h00020, 8'h00, 8'd20, 16'h0002, 1'b0, 4'd0, 4'd0, 8'd16, 8'h0F, 1'b1},
    '{2'd1, 20'h00000, 8'h00, 8'd0,  16'h0000, 1'b0, 4'd1, 4'd0, 8'd0,  8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input bit big, input logic [1:0] op, input logic [19:0] a,
                         input logic [7:0] wd, input logic [7:0] noise,
                         output logic [7:0] rd, output logic err);
    bit seen;
    @(negedge clk);
    if (big) begin l_arm = 1; l_an = noise; end else begin s_arm = 1; s_an = noise; end
    @(negedge clk);
    s_arm = 0; l_arm = 0;
    if (big) begin l_valid = 1; l_op = op; l_addr = a; l_wd = wd; end
    else begin s_valid = 1; s_op = op; s_addr = a; s_wd = wd; end
    seen = 0;
    for (int t = 0; t < 2000 && !seen; t++) begin
      @(negedge clk);
      seen = big ? l_ack : s_ack;
    end
    check("R12 ack arrives", 32'(seen), 32'd1);
    rd = big ? l_rd : s_rd;
    err = big ? l_err : s_err;
    s_valid = 0; l_valid = 0;
    @(negedge clk);
    check("R12 ack one cycle", 32'(big ? l_ack : s_ack), 32'd0);
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic err;
    int cw0, sw0, ns0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    check("R1 small ack", 32'(s_ack), 0);
    check("R1 small req", 32'(s_req), 0);
    check("R1 large ack", 32'(l_ack), 0);
    check("R1 large req", 32'(l_req), 0);

    // Vector table, 128 KiB mode: R2 R3 R4 R6 R7 R8 R9 R11
    for (int i = 0; i < 8; i++) begin
      cw0 = u_ms.cw_cnt; sw0 = u_ms.sw_cnt; ns0 = u_ms.drd_cnt;
      run_cmd(1'b0, VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].noise, rd, err);
      check($sformatf("R2/R3/R4 ctrl word v%0d", i), 32'(u_ms.ctrl), 32'(VECS[i].e_ctrl));
      check($sformatf("R4 ctrl write count v%0d", i), 32'(u_ms.cw_cnt - cw0), 32'(VECS[i].e_cw));
      check($sformatf("R11 select value v%0d", i), 32'(u_ms.sel[0]), 32'(VECS[i].e_sel));
      check($sformatf("R11 select writes v%0d", i), 32'(u_ms.sw_cnt - sw0), 32'(VECS[i].e_sw));
      check($sformatf("R6 read-back order v%0d", i), 32'(u_ms.viol), 0);
      check($sformatf("R8/R9 sample count v%0d", i), 32'(u_ms.drd_cnt - ns0), 32'(VECS[i].e_ns));
      if (VECS[i].op == 2'd2) begin
        check($sformatf("R8/R9 read byte v%0d", i), 32'(rd), 32'(VECS[i].e_rd));
        check($sformatf("R9 error flag v%0d", i), 32'(err), 32'(VECS[i].e_err));
      end
      if (VECS[i].op >= 2'd2)
        check($sformatf("R7 flash address v%0d", i), 32'(u_ms.faddr), 32'(VECS[i].addr[15:0]));
      if (VECS[i].op == 2'd3)
        check($sformatf("R7 write data v%0d", i), 32'(u_ms.lastw), 32'({8'd0, VECS[i].wd}));
    end

    // Directed, 1 MiB mode
    cw0 = u_ml.cw_cnt;
    run_cmd(1'b1, 2'd0, 20'h0, 8'h0, 8'd0, rd, err);
    check("R2 large open ctrl", 32'(u_ml.ctrl), 32'h0002);
    check("R2 large no select writes", 32'(u_ml.sw_cnt), 0);
    ns0 = u_ml.drd_cnt;
    run_cmd(1'b1, 2'd2, 20'hA1234, 8'h0, 8'd5, rd, err);
    check("R5 bank field A", 32'(u_ml.ctrl), 32'h00AA);
    check("R10 single sample", 32'(u_ml.drd_cnt - ns0), 1);
    check("R10 first sample byte", 32'(rd), 32'h00);
    check("R10 no error", 32'(err), 0);
    cw0 = u_ml.cw_cnt;
    run_cmd(1'b1, 2'd2, 20'hA1234, 8'h0, 8'd0, rd, err);
    check("R5 rewrite every access", 32'(u_ml.cw_cnt - cw0), 1);
    check("R10 clean byte", 32'(rd), 32'h26);
    run_cmd(1'b1, 2'd3, 20'h3FFFF, 8'h5C, 8'd0, rd, err);
    check("R5 bank field cleared and set 3", 32'(u_ml.ctrl), 32'h003A);
    check("R7 large flash address", 32'(u_ml.faddr), 32'hFFFF);
    check("R7 large write data", 32'(u_ml.lastw), 32'h005C);
    run_cmd(1'b1, 2'd1, 20'h0, 8'h0, 8'd0, rd, err);
    check("R3 large close ctrl", 32'(u_ml.ctrl), 32'h0038);
    check("R6 large read-back order", 32'(u_ml.viol), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule